// File: doc/BRIEF.md
# Stack-Snooping Two-Bank Cartridge Mapper

This block selects which of two 4 KB ROM banks appears in the cartridge window at $F000-$FFFF. It has no hotspot addresses. Instead it watches the processor's address and data buses without driving them. A subroutine call or return always touches the stack byte at $01FE. On the bus cycle that comes next, the data bus carries the high byte of a return address. One bit of that byte chooses the bank.

A two-state detector does this work. It arms on a valid cycle at $01FE, and on the next valid cycle it samples data bit 5. A clear bit selects bank 1 and a set bit selects bank 0. The other seven bits have no effect. The bank register changes at the clock edge that ends the sampled cycle, so the new bank drives the upper ROM address line from the following cycle on. The processor's reset sequence also touches $01FE, just before the vector fetch. Because of this, a zero vector low byte moves the mapper to bank 1.

Top module: `snoop_bank_mapper`

## Requirements
- R1: A synchronous active-high reset sets the bank output to 0 and leaves the detector idle, so the first valid cycle after reset is not sampled unless it is preceded by a $01FE cycle after reset.
- R2: A valid cycle at address $01FE arms the detector. The data byte of the next valid cycle is sampled, and when its bit 5 is 0 the bank output becomes 1.
- R3: When bit 5 of the sampled byte is 1, the bank output becomes 0.
- R4: All data bits other than bit 5 are ignored. In particular, top-three-bit patterns 000 and 110 select bank 1, and 111 selects bank 0.
- R5: The bank output keeps its old value during the $01FE cycle and during the sampled cycle. It takes the new value in the cycle after the sampled one.
- R6: Exactly one cycle is sampled per arming. Data on later valid cycles leaves the bank unchanged until another $01FE cycle occurs.
- R7: Valid cycles at any address other than $01FE do not arm the detector. This includes $01FD, $01FF and $11FE.
- R8: When an armed detector sees another $01FE cycle, that cycle's data is sampled, and the cycle also arms the detector again, so the following valid cycle is sampled too.
- R9: Cycles with the valid strobe low are ignored. They neither arm the detector nor get sampled, and an armed detector stays armed across them.
- R10: A reset-like sequence of $0100, $01FF, $01FE followed by a vector fetch at $FFFC with data $00 leaves the mapper in bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_bus | input | 16 | Processor address bus |
| data_bus | input | 8 | Processor data bus |
| cyc_valid | input | 1 | High on cycles that carry a real bus transfer |
| bank_sel | output | 1 | Active bank number, drives the upper ROM address line |

## Verification
The detector arms at the edge that ends the $01FE cycle. The bank register loads at the edge that ends the next valid cycle, so a selection shows on bank_sel two edges after the trigger is driven. The bench drives each bus cycle on the falling edge and reads bank_sel just after the following rising edge. This places the check right after the edge that ends the trigger cycle, where the old bank must still hold, and right after the edge that ends the data cycle, where the new bank must show. Cases for idle strobes, back-to-back triggers and reset follow the same edge count.

// File: rtl/snoop_map_pkg.sv
package snoop_map_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int NUM_BANKS = 2;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam logic [ADDR_W-1:0] STACK_TRIG = 16'h01FE;
    localparam int SEL_BIT   = 5;
    localparam logic [DATA_W-1:0] SEL_MASK = DATA_W'(1) << SEL_BIT;

    typedef enum logic {
        DET_IDLE  = 1'b0,
        DET_ARMED = 1'b1
    } det_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              valid;
    } bus_cycle_t;

    typedef logic [BANK_W-1:0] bank_t;

    // A clear select bit picks bank 1, a set one picks bank 0.
    function automatic bank_t bank_from_byte(input logic [DATA_W-1:0] b);
        return (|(b & SEL_MASK)) ? bank_t'(0) : bank_t'(1);
    endfunction

endpackage

// File: rtl/snoop_addr_match.sv
module snoop_addr_match
    import snoop_map_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MATCH_ADDR = STACK_TRIG
) (
    input  bus_cycle_t cyc,
    output logic       hit
);
    always_comb begin
        hit = cyc.valid && (cyc.addr == MATCH_ADDR);
    end
endmodule

// File: rtl/snoop_arm_fsm.sv
module snoop_arm_fsm
    import snoop_map_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cyc_valid,
    input  logic trig_hit,
    output logic sample_now,
    output logic armed
);
    det_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (cyc_valid) begin
            state_d = trig_hit ? DET_ARMED : DET_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DET_IDLE;
        else     state_q <= state_d;
    end

    assign armed      = (state_q == DET_ARMED);
    assign sample_now = armed && cyc_valid;
endmodule

// File: rtl/snoop_bank_reg.sv
module snoop_bank_reg
    import snoop_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] sel_byte,
    output bank_t             bank
);
    bank_t bank_q;

    always_ff @(posedge clk) begin
        if (rst)       bank_q <= bank_t'(0);
        else if (load) bank_q <= bank_from_byte(sel_byte);
    end

    assign bank = bank_q;
endmodule

// File: rtl/snoop_bank_mapper.sv
module snoop_bank_mapper
    import snoop_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_bus,
    input  logic [DATA_W-1:0] data_bus,
    input  logic              cyc_valid,
    output logic [BANK_W-1:0] bank_sel
);
    bus_cycle_t cyc;
    logic       trig_hit;
    logic       sample_now;
    logic       det_armed;

    always_comb begin
        cyc.addr  = addr_bus;
        cyc.data  = data_bus;
        cyc.valid = cyc_valid;
    end

    snoop_addr_match #(.MATCH_ADDR(STACK_TRIG)) u_match (
        .cyc (cyc),
        .hit (trig_hit)
    );

    snoop_arm_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cyc_valid  (cyc.valid),
        .trig_hit   (trig_hit),
        .sample_now (sample_now),
        .armed      (det_armed)
    );

    snoop_bank_reg u_bank (
        .clk      (clk),
        .rst      (rst),
        .load     (sample_now),
        .sel_byte (cyc.data),
        .bank     (bank_sel)
    );
endmodule

// File: rtl/snoop_bank_mapper_chk.sv
module snoop_bank_mapper_chk
    import snoop_map_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_bus,
    input logic [DATA_W-1:0] data_bus,
    input logic              cyc_valid,
    input logic [BANK_W-1:0] bank_sel,
    input logic              armed
);
    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (bank_sel == '0 && !armed)); // R1
    AST_SAMPLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (armed && cyc_valid && !data_bus[SEL_BIT]) |=> (bank_sel == BANK_W'(1))); // R2
    AST_SAMPLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (armed && cyc_valid && data_bus[SEL_BIT]) |=> (bank_sel == '0)); // R3
    AST_HOLD_UNSAMPLED: assert property (@(posedge clk) disable iff (rst)
        !(armed && cyc_valid) |=> $stable(bank_sel)); // R6
    AST_TRIG_ARMS: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && addr_bus == STACK_TRIG) |=> armed); // R8
    AST_OTHER_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && addr_bus != STACK_TRIG) |=> !armed); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |=> $stable(armed)); // R9
endmodule

bind snoop_bank_mapper snoop_bank_mapper_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .addr_bus  (addr_bus),
    .data_bus  (data_bus),
    .cyc_valid (cyc_valid),
    .bank_sel  (bank_sel),
    .armed     (det_armed)
);

// File: tb/tb_snoop_bank_mapper.sv
module tb_snoop_bank_mapper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr_bus = 16'h0000;
    logic [7:0]  data_bus = 8'h00;
    logic        cyc_valid = 1'b0;
    logic [0:0]  bank_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    snoop_bank_mapper dut (
        .clk       (clk),
        .rst       (rst),
        .addr_bus  (addr_bus),
        .data_bus  (data_bus),
        .cyc_valid (cyc_valid),
        .bank_sel  (bank_sel)
    );

    // {trigger address, byte on following cycle, expected bank afterwards}
    typedef struct packed {
        logic [15:0] trig;
        logic [7:0]  data;
        logic        bank;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{16'h01FE, 8'h00, 1'b1},  // R4 000 -> bank 1
        '{16'h01FE, 8'h20, 1'b0},  // R3
        '{16'h01FE, 8'hDF, 1'b1},  // R2, R4
        '{16'h01FE, 8'hE0, 1'b0},  // R4 111
        '{16'h01FE, 8'hC0, 1'b1},  // R4 110
        '{16'h01FE, 8'h40, 1'b1},  // R2
        '{16'h01FD, 8'h20, 1'b1},  // R7
        '{16'h01FE, 8'hF0, 1'b0},  // R3
        '{16'h11FE, 8'h00, 1'b0},  // R7
        '{16'h01FF, 8'h00, 1'b0},  // R7
        '{16'h01FE, 8'h3F, 1'b0},  // R4
        '{16'h01FE, 8'h80, 1'b1}   // R4
    };

    task automatic step(input logic [15:0] a, input logic [7:0] d, input logic v);
        @(negedge clk);
        addr_bus  = a;
        data_bus  = d;
        cyc_valid = v;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic exp, input string req);
        checks++;
        if (bank_sel !== exp) begin
            fails++;
            $display("FAIL %s bank_sel actual=%0b expected=%0b", req, bank_sel, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cyc_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic prev;
        repeat (2) @(posedge clk);
        #1;
        chk(1'b0, "R1 reset value");
        do_reset();

        prev = 1'b0;
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].trig, 8'h00, 1'b1);
            chk(prev, "R5 no change on trigger cycle");
            step(16'hFFFC, VECS[i].data, 1'b1);
            chk(VECS[i].bank, "R2/R3/R4/R7 table entry");
            prev = VECS[i].bank;
        end

        // R6: only one cycle sampled (bank is 1 now)
        step(16'hF123, 8'h20, 1'b1);
        chk(1'b1, "R6 second data cycle ignored");

        // R1: reset clears an armed detector
        step(16'h01FE, 8'h00, 1'b1);
        do_reset();
        chk(1'b0, "R1 reset clears bank");
        step(16'hFFFC, 8'h00, 1'b1);
        chk(1'b0, "R1 detector idle after reset");

        // R8: back-to-back triggers
        step(16'h01FE, 8'h00, 1'b1);
        step(16'h01FE, 8'h00, 1'b1);
        chk(1'b1, "R8 second trigger data sampled");
        step(16'hFFFC, 8'h20, 1'b1);
        chk(1'b0, "R8 re-armed by second trigger");

        // R9: idle cycles ignored and hold the arm
        step(16'h01FE, 8'h20, 1'b1);
        step(16'h1234, 8'h00, 1'b0);
        chk(1'b0, "R9 idle cycle not sampled");
        step(16'hFFFC, 8'h00, 1'b1);
        chk(1'b1, "R9 arm held across idle cycle");
        step(16'h01FE, 8'h00, 1'b0);
        step(16'hFFFC, 8'h20, 1'b1);
        chk(1'b1, "R9 idle trigger does not arm");

        // R10: reset-like stack sequence then zero vector byte
        do_reset();
        step(16'h0100, 8'h00, 1'b1);
        step(16'h01FF, 8'h00, 1'b1);
        step(16'h01FE, 8'h00, 1'b1);
        chk(1'b0, "R10 still bank 0 before vector");
        step(16'hFFFC, 8'h00, 1'b1);
        chk(1'b1, "R10 zero vector byte selects bank 1");
        step(16'hFFFD, 8'hF0, 1'b1);
        chk(1'b1, "R10 vector high byte ignored");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule